// File: doc/BRIEF.md
# Majority-Voting Serial Receiver with Packet CRC

This block turns an asynchronous serial line into bytes. A sampling tick arrives sixteen times per bit period. Each bit is settled by a two-of-three vote over the samples at ticks 7, 8 and 9 of that bit, so a single corrupted sample near the bit centre cannot change the result. The frame has one start bit and eight data bits sent LSB first. A wakeup bit, a parity bit and a second stop bit can each be added by a format input. Completed bytes, each with its wakeup bit, go into a four-entry receive FIFO that the host drains with a read strobe.

Every completed byte also feeds a running CRC. When the line has been quiet for one full character time after the last byte, the CRC residue is tested. A correct residue marks the end of a packet. A wrong residue raises a CRC error. In both cases the CRC restarts for the next packet. Parity, framing, overrun and CRC errors are sticky and do not stop reception. One clear strobe drops all status flags. An interrupt request is raised while the FIFO is full or a packet end is pending.

Top module: `mvote_rx`

## Requirements
- R1: Every bit value is the majority of the three line samples taken at ticks 7, 8 and 9 of the bit, counting from tick 0, which is the first tick that sees the line low. Inverting any one of these samples does not change the received bit.
- R2: A start bit whose vote is high is treated as noise. No byte is produced, and the receiver waits for the next low level.
- R3: While rx_en_i is low the receiver stays idle and produces no byte. Dropping rx_en_i in the middle of a frame abandons that frame.
- R4: Frame order on the line is: start (0), then data bits 0 to 7, then the wakeup bit if wake_en_i is set, then the parity bit if par_en_i is set, then the first stop bit, then a second stop bit if two_stop_i is set. The received wakeup bit is presented on rd_wake_o next to the data. It reads 0 when wake_en_i is clear.
- R5: With par_en_i set, a parity error is flagged when the XOR of the data bits, the wakeup bit and the parity bit differs from par_odd_i (0 selects even parity, 1 selects odd). The byte is still stored.
- R6: A framing error is flagged when the first stop bit votes low. The byte is still stored. The value of the second stop bit is ignored.
- R7: A byte that completes while the FIFO holds 4 entries sets the overrun flag and is discarded. The stored entries are left unchanged.
- R8: The FIFO returns bytes in arrival order. rd_valid_o shows it is non-empty, rd_i removes the head entry, and buf_full_o shows 4 entries. After reset the FIFO is empty and every flag is clear.
- R9: The running CRC starts at 0xFFFF, uses polynomial 0x1021 and takes each byte MSB first. After one character time of idle line (16 × (10 + wake + parity + extra stop) ticks) following at least one byte, a residue of 0x1D0F sets pkt_end_o. Any other residue sets err_crc_o. The CRC then restarts at 0xFFFF.
- R10: err_par_o, err_frm_o, err_ovr_o, err_crc_o and pkt_end_o stay set until clr_i, and reception goes on while they are set.
- R11: irq_o is high exactly when buf_full_o or pkt_end_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sampling strobe, 16 per bit period |
| rx_i | input | 1 | Serial line, idle high |
| rx_en_i | input | 1 | Receive enable |
| wake_en_i | input | 1 | Frame carries a wakeup bit |
| par_en_i | input | 1 | Frame carries a parity bit |
| par_odd_i | input | 1 | Parity sense: 0 even, 1 odd |
| two_stop_i | input | 1 | Frame carries two stop bits |
| clr_i | input | 1 | Clear all sticky flags |
| rd_i | input | 1 | Remove FIFO head |
| rd_data_o | output | 8 | FIFO head data |
| rd_wake_o | output | 1 | FIFO head wakeup bit |
| rd_valid_o | output | 1 | FIFO not empty |
| buf_full_o | output | 1 | FIFO holds 4 entries |
| pkt_end_o | output | 1 | Packet ended with good CRC |
| err_crc_o | output | 1 | CRC residue wrong at packet end |
| err_par_o | output | 1 | Parity error |
| err_ovr_o | output | 1 | Overrun error |
| err_frm_o | output | 1 | Framing error |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that the format inputs change only while the line is idle and no packet is being timed. They also assume that tick_i is a single-cycle strobe and that rd_i is not pulsed on an empty FIFO while a byte is completing into a full one. The stimulus meets these conditions. It changes the format only after a long idle gap, and it drives the line one tick slot at a time, so each vote sample is a deliberate choice. It reads and clears only between tick slots. Each frame ends with the line high long enough that a noise start cannot overlap the next start bit.

// File: rtl/mvrx_pkg.sv
package mvrx_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [15:0] CRC_INIT = 16'hFFFF;
  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_GOOD = 16'h1D0F;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_WAKE, ST_PAR, ST_STOP1, ST_STOP2
  } rx_state_e;

  typedef struct packed {
    logic              wake;
    logic [BYTE_W-1:0] data;
  } rx_word_t;

  function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [BYTE_W-1:0] d);
    logic [15:0] r;
    r = c;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ CRC_POLY;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction
endpackage

// File: rtl/mvrx_deser.sv
module mvrx_deser
  import mvrx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  logic     rx_i,
  input  logic     en_i,
  input  logic     wake_en_i,
  input  logic     par_en_i,
  input  logic     par_odd_i,
  input  logic     two_stop_i,
  output logic     busy_o,
  output logic     done_o,
  output rx_word_t word_o,
  output logic     par_err_o,
  output logic     frm_err_o
);
  localparam int unsigned PH_W = $clog2(OVS);
  localparam int unsigned MID  = OVS / 2;
  localparam logic [PH_W-1:0] PH_V0   = PH_W'(MID - 1);
  localparam logic [PH_W-1:0] PH_V1   = PH_W'(MID);
  localparam logic [PH_W-1:0] PH_V2   = PH_W'(MID + 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVS - 1);

  rx_state_e         state_q;
  logic [PH_W-1:0]   ph_q;
  logic [2:0]        idx_q;
  logic [BYTE_W-1:0] sh_q;
  logic [1:0]        ones_q;
  logic              bit_q, wake_q, par_q, frm_q;
  logic [1:0]        vote_sum;
  logic              vote;
  rx_state_e         after_data, after_wake;

  always_comb begin
    vote_sum   = ones_q + {1'b0, rx_i};
    vote       = vote_sum[1];
    after_wake = par_en_i ? ST_PAR : ST_STOP1;
    after_data = wake_en_i ? ST_WAKE : after_wake;
  end

  assign busy_o = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      ph_q      <= '0;
      idx_q     <= '0;
      sh_q      <= '0;
      ones_q    <= '0;
      bit_q     <= 1'b1;
      wake_q    <= 1'b0;
      par_q     <= 1'b0;
      frm_q     <= 1'b0;
      done_o    <= 1'b0;
      word_o    <= '0;
      par_err_o <= 1'b0;
      frm_err_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!en_i) begin
        state_q <= ST_IDLE;
      end else if (tick_i) begin
        if (state_q == ST_IDLE) begin
          if (!rx_i) begin
            state_q <= ST_START;
            ph_q    <= PH_W'(1);
            ones_q  <= '0;
          end
        end else begin
          ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
          if (ph_q == PH_V0 || ph_q == PH_V1) ones_q <= ones_q + {1'b0, rx_i};
          if (ph_q == PH_V2) begin
            bit_q  <= vote;
            ones_q <= '0;
            unique case (state_q)
              ST_START: if (vote) state_q <= ST_IDLE;
              ST_STOP1: begin
                frm_q <= ~vote;
                if (!two_stop_i) begin
                  state_q   <= ST_IDLE;
                  done_o    <= 1'b1;
                  word_o    <= '{wake: wake_q, data: sh_q};
                  par_err_o <= par_en_i & ((^sh_q ^ wake_q ^ par_q) != par_odd_i);
                  frm_err_o <= ~vote;
                end
              end
              ST_STOP2: begin
                state_q   <= ST_IDLE;
                done_o    <= 1'b1;
                word_o    <= '{wake: wake_q, data: sh_q};
                par_err_o <= par_en_i & ((^sh_q ^ wake_q ^ par_q) != par_odd_i);
                frm_err_o <= frm_q;
              end
              default: ;
            endcase
          end
          if (ph_q == PH_LAST) begin
            unique case (state_q)
              ST_START: begin
                state_q <= ST_DATA;
                idx_q   <= '0;
                wake_q  <= 1'b0;
                par_q   <= 1'b0;
              end
              ST_DATA: begin
                sh_q <= {bit_q, sh_q[BYTE_W-1:1]};
                if (idx_q == 3'(BYTE_W - 1)) state_q <= after_data;
                else                         idx_q   <= idx_q + 1'b1;
              end
              ST_WAKE: begin
                wake_q  <= bit_q;
                state_q <= after_wake;
              end
              ST_PAR: begin
                par_q   <= bit_q;
                state_q <= ST_STOP1;
              end
              ST_STOP1: state_q <= ST_STOP2;
              default: ;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/mvrx_fifo.sv
module mvrx_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 9,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic          valid_o,
  output logic          full_o,
  output logic [CW-1:0] count_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign valid_o = (cnt_q != '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign count_o = cnt_q;
  assign rdata_o = mem_q[rp_q];
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & valid_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (do_push) begin
        mem_q[wp_q] <= wdata_i;
        wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      end
      if (do_pop) rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/mvrx_crc_mon.sv
module mvrx_crc_mon
  import mvrx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              byte_done_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              rx_busy_i,
  input  logic              wake_en_i,
  input  logic              par_en_i,
  input  logic              two_stop_i,
  output logic              pkt_end_o,
  output logic              crc_bad_o
);
  localparam int unsigned CNT_W = $clog2(OVS * 13 + 1);

  logic [15:0]      crc_q;
  logic             armed_q;
  logic [CNT_W-1:0] idle_q, char_len;
  logic [3:0]       nbits;

  always_comb begin
    nbits    = 4'd10 + {3'b0, wake_en_i} + {3'b0, par_en_i} + {3'b0, two_stop_i};
    char_len = CNT_W'(OVS) * CNT_W'(nbits);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q     <= CRC_INIT;
      armed_q   <= 1'b0;
      idle_q    <= '0;
      pkt_end_o <= 1'b0;
      crc_bad_o <= 1'b0;
    end else begin
      pkt_end_o <= 1'b0;
      crc_bad_o <= 1'b0;
      if (byte_done_i) begin
        crc_q   <= crc16_byte(crc_q, byte_i);
        armed_q <= 1'b1;
        idle_q  <= '0;
      end else if (rx_busy_i) begin
        idle_q <= '0;
      end else if (tick_i && armed_q) begin
        if (idle_q == char_len - 1'b1) begin
          pkt_end_o <= (crc_q == CRC_GOOD);
          crc_bad_o <= (crc_q != CRC_GOOD);
          crc_q     <= CRC_INIT;
          armed_q   <= 1'b0;
          idle_q    <= '0;
        end else begin
          idle_q <= idle_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mvote_rx.sv
module mvote_rx
  import mvrx_pkg::*;
#(
  parameter int unsigned OVS         = 16,
  parameter int unsigned DEPTH       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic              rx_en_i,
  input  logic              wake_en_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              two_stop_i,
  input  logic              clr_i,
  input  logic              rd_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              rd_wake_o,
  output logic              rd_valid_o,
  output logic              buf_full_o,
  output logic              pkt_end_o,
  output logic              err_crc_o,
  output logic              err_par_o,
  output logic              err_ovr_o,
  output logic              err_frm_o,
  output logic              irq_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned NF = 5;

  logic          rx_s;
  logic          busy, frame_done, par_err, frm_err, pkt_hit, crc_bad;
  rx_word_t      word, head;
  logic [CW-1:0] fifo_cnt;
  logic [NF-1:0] flag_q, flag_set;

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign rx_s = rx_i;
    end else if (SYNC_STAGES == 1) begin : g_sync1
      logic s_q;
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) s_q <= 1'b1;
        else         s_q <= rx_i;
      assign rx_s = s_q;
    end else begin : g_syncn
      logic [SYNC_STAGES-1:0] s_q;
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) s_q <= '1;
        else         s_q <= {s_q[SYNC_STAGES-2:0], rx_i};
      assign rx_s = s_q[SYNC_STAGES-1];
    end
  endgenerate

  mvrx_deser #(.OVS(OVS)) u_deser (
    .clk_i, .rst_ni, .tick_i,
    .rx_i       (rx_s),
    .en_i       (rx_en_i),
    .wake_en_i, .par_en_i, .par_odd_i, .two_stop_i,
    .busy_o     (busy),
    .done_o     (frame_done),
    .word_o     (word),
    .par_err_o  (par_err),
    .frm_err_o  (frm_err)
  );

  mvrx_fifo #(.DEPTH(DEPTH), .W($bits(rx_word_t))) u_fifo (
    .clk_i, .rst_ni,
    .push_i  (frame_done),
    .wdata_i (word),
    .pop_i   (rd_i),
    .rdata_o (head),
    .valid_o (rd_valid_o),
    .full_o  (buf_full_o),
    .count_o (fifo_cnt)
  );

  mvrx_crc_mon #(.OVS(OVS)) u_crc (
    .clk_i, .rst_ni, .tick_i,
    .byte_done_i (frame_done),
    .byte_i      (word.data),
    .rx_busy_i   (busy),
    .wake_en_i, .par_en_i, .two_stop_i,
    .pkt_end_o   (pkt_hit),
    .crc_bad_o   (crc_bad)
  );

  // set wins over a simultaneous clear
  assign flag_set = {pkt_hit, crc_bad,
                     frame_done & par_err,
                     frame_done & buf_full_o,
                     frame_done & frm_err};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= flag_set | (flag_q & ~{NF{clr_i}});
  end

  assign {pkt_end_o, err_crc_o, err_par_o, err_ovr_o, err_frm_o} = flag_q;
  assign rd_data_o = head.data;
  assign rd_wake_o = head.wake;
  assign irq_o     = buf_full_o | pkt_end_o;
endmodule

// File: rtl/mvote_rx_chk.sv
module mvote_rx_chk #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rx_en_i,
  input logic          clr_i,
  input logic          rd_i,
  input logic          done_i,
  input logic          full_i,
  input logic          rd_valid_i,
  input logic          pkt_end_i,
  input logic          err_crc_i,
  input logic          err_par_i,
  input logic          err_ovr_i,
  input logic          err_frm_i,
  input logic [CW-1:0] fifo_cnt_i
);
  p_off_no_rx_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> !done_i);

  p_ovr_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && full_i |=> err_ovr_i);

  p_ovr_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && full_i && !rd_i |=> full_i);

  p_drain_by_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_valid_i) |-> $past(rd_i));

  p_grow_by_frame_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_cnt_i > $past(fifo_cnt_i)) |-> $past(done_i));

  p_pkt_or_crc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($rose(pkt_end_i) && $rose(err_crc_i)));

  p_sticky_par_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_par_i && !clr_i |=> err_par_i);

  p_sticky_frm_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_frm_i && !clr_i |=> err_frm_i);

  p_sticky_ovr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_ovr_i && !clr_i |=> err_ovr_i);

  p_sticky_crc_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_crc_i && !clr_i |=> err_crc_i);

  p_sticky_pkt_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_end_i && !clr_i |=> pkt_end_i);
endmodule

bind mvote_rx mvote_rx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rx_en_i    (rx_en_i),
  .clr_i      (clr_i),
  .rd_i       (rd_i),
  .done_i     (frame_done),
  .full_i     (buf_full_o),
  .rd_valid_i (rd_valid_o),
  .pkt_end_i  (pkt_end_o),
  .err_crc_i  (err_crc_o),
  .err_par_i  (err_par_o),
  .err_ovr_i  (err_ovr_o),
  .err_frm_i  (err_frm_o),
  .fifo_cnt_i (fifo_cnt)
);

// File: tb/mvote_rx_test.sv
`timescale 1ns/1ps
module mvote_rx_test;
  localparam int OVS = 16;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0, rx_i = 1'b1, rx_en_i = 1'b1;
  logic wake_en_i = 1'b0, par_en_i = 1'b0, par_odd_i = 1'b0, two_stop_i = 1'b0;
  logic clr_i = 1'b0, rd_i = 1'b0;
  logic [7:0] rd_data_o;
  logic rd_wake_o, rd_valid_o, buf_full_o, pkt_end_o;
  logic err_crc_o, err_par_o, err_ovr_o, err_frm_o, irq_o;

  always #2 clk = ~clk;

  mvote_rx uut (
    .clk_i(clk), .rst_ni, .tick_i, .rx_i, .rx_en_i, .wake_en_i, .par_en_i,
    .par_odd_i, .two_stop_i, .clr_i, .rd_i, .rd_data_o, .rd_wake_o,
    .rd_valid_o, .buf_full_o, .pkt_end_o, .err_crc_o, .err_par_o,
    .err_ovr_o, .err_frm_o, .irq_o
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  logic [8:0]  q_m[$];
  logic [15:0] crc_m = 16'hFFFF;
  bit armed_m = 0;
  bit pkt_e = 0, crc_e = 0, par_e = 0, ovr_e = 0, frm_e = 0;

  function automatic logic [15:0] crc_step(logic [15:0] c, logic [7:0] d);
    logic [15:0] r = c;
    for (int k = 0; k < 8; k++) begin
      logic top = r[15] ^ d[7 - k];
      r = r << 1;
      if (top) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic one_tick(input logic v);
    @(negedge clk); rx_i = v; tick_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
  endtask

  // glitch_bit: line bit index whose tick-8 sample is inverted, -1 none
  task automatic send_frame(input logic [7:0] d, input logic w, input bit bad_par,
                            input bit bad_stop, input int glitch_bit);
    logic bits[16];
    int nb = 0;
    logic p;
    bits[nb++] = 1'b0;
    for (int i = 0; i < 8; i++) bits[nb++] = d[i];
    if (wake_en_i) bits[nb++] = w;
    p = (^d) ^ (wake_en_i & w) ^ par_odd_i ^ bad_par;
    if (par_en_i) bits[nb++] = p;
    bits[nb++] = bad_stop ? 1'b0 : 1'b1;
    if (two_stop_i) bits[nb++] = 1'b1;
    for (int b = 0; b < nb; b++)
      for (int t = 0; t < OVS; t++)
        one_tick((b == glitch_bit && t == 8) ? ~bits[b] : bits[b]);
    if (bad_stop) repeat (OVS) one_tick(1'b1);
    if (rx_en_i) begin
      crc_m = crc_step(crc_m, d);
      armed_m = 1;
      if (q_m.size() == DEPTH) ovr_e = 1;
      else q_m.push_back({wake_en_i & w, d});
      if (par_en_i && bad_par) par_e = 1;
      if (bad_stop) frm_e = 1;
    end
  endtask

  task automatic long_idle();
    repeat (OVS * 14 + 8) one_tick(1'b1);
    if (armed_m) begin
      if (crc_m == 16'h1D0F) pkt_e = 1; else crc_e = 1;
      crc_m = 16'hFFFF;
      armed_m = 0;
    end
  endtask

  task automatic compare_all(input string req);
    @(negedge clk);
    chk(req, "rd_valid", rd_valid_o, q_m.size() != 0);
    chk(req, "buf_full", buf_full_o, q_m.size() == DEPTH);
    chk(req, "pkt_end", pkt_end_o, pkt_e);
    chk(req, "err_crc", err_crc_o, crc_e);
    chk(req, "err_par", err_par_o, par_e);
    chk(req, "err_ovr", err_ovr_o, ovr_e);
    chk(req, "err_frm", err_frm_o, frm_e);
    chk("R11", "irq", irq_o, (q_m.size() == DEPTH) || pkt_e);
    if (q_m.size() != 0) chk(req, "head", {rd_wake_o, rd_data_o}, q_m[0]);
  endtask

  task automatic read_all(input string req);
    while (q_m.size() != 0) begin
      @(negedge clk);
      chk(req, "read data", {rd_wake_o, rd_data_o}, q_m[0]);
      rd_i = 1'b1;
      @(negedge clk); rd_i = 1'b0;
      void'(q_m.pop_front());
    end
    compare_all(req);
  endtask

  task automatic clear_flags();
    @(negedge clk); clr_i = 1'b1;
    @(negedge clk); clr_i = 1'b0;
    pkt_e = 0; crc_e = 0; par_e = 0; ovr_e = 0; frm_e = 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] c;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    compare_all("R8 reset");

    // R4 R8: plain bytes, order kept, then idle gives a CRC verdict (R9)
    send_frame(8'hA5, 0, 0, 0, -1);
    send_frame(8'h3C, 0, 0, 0, -1);
    compare_all("R4");
    long_idle();
    compare_all("R9 idle verdict");
    read_all("R8");
    clear_flags();
    compare_all("R10 clear");

    // R9 good packet: two bytes plus inverted CRC MSB first; fills FIFO (R11)
    c = crc_step(crc_step(16'hFFFF, 8'h12), 8'h34);
    c = ~c;
    send_frame(8'h12, 0, 0, 0, -1);
    send_frame(8'h34, 0, 0, 0, -1);
    send_frame(c[15:8], 0, 0, 0, -1);
    send_frame(c[7:0], 0, 0, 0, -1);
    compare_all("R11 full");
    long_idle();
    chk("R9", "pkt_end good", pkt_end_o, 1'b1);
    compare_all("R9");
    read_all("R11 pkt");
    clear_flags();

    // R1: single bad sample in data bit and in start bit
    send_frame(8'h55, 0, 0, 0, 3);
    send_frame(8'hC3, 0, 0, 0, 0);
    send_frame(8'h0F, 0, 0, 0, 8);
    compare_all("R1");
    read_all("R1");
    long_idle();
    clear_flags();

    // R2: short low pulse rejected
    repeat (5) one_tick(1'b0);
    repeat (40) one_tick(1'b1);
    compare_all("R2");

    // R3: disabled, including drop mid-frame
    rx_en_i = 1'b0;
    send_frame(8'h77, 0, 0, 0, -1);
    compare_all("R3 off");
    rx_en_i = 1'b1;
    repeat (20) one_tick(1'b0);
    rx_en_i = 1'b0;
    repeat (OVS * 12) one_tick(1'b1);
    rx_en_i = 1'b1;
    repeat (20) one_tick(1'b1);
    compare_all("R3 abort");

    // R5 parity, even then odd; R10 sticky while reception continues
    par_en_i = 1'b1; par_odd_i = 1'b0;
    send_frame(8'h0F, 0, 0, 0, -1);
    compare_all("R5 even ok");
    send_frame(8'h81, 0, 1, 0, -1);
    compare_all("R5 even bad");
    par_odd_i = 1'b1;
    send_frame(8'h07, 0, 0, 0, -1);
    compare_all("R10 sticky par");
    long_idle();
    clear_flags();
    send_frame(8'h07, 0, 1, 0, -1);
    compare_all("R5 odd bad");
    read_all("R5");
    long_idle();
    clear_flags();
    par_en_i = 1'b0; par_odd_i = 1'b0;
    long_idle();

    // R6 framing, then two stop bits
    send_frame(8'h99, 0, 0, 1, -1);
    compare_all("R6 frame");
    long_idle();
    clear_flags();
    two_stop_i = 1'b1;
    long_idle();
    send_frame(8'h66, 0, 0, 0, -1);
    send_frame(8'h99, 0, 0, 1, -1);
    compare_all("R6 two stop");
    read_all("R6");
    long_idle();
    clear_flags();
    two_stop_i = 1'b0;
    long_idle();

    // R4 wake bit with parity
    wake_en_i = 1'b1; par_en_i = 1'b1;
    long_idle();
    send_frame(8'hAB, 1, 0, 0, -1);
    send_frame(8'h01, 0, 0, 0, -1);
    send_frame(8'h80, 1, 1, 0, -1);
    compare_all("R4 wake");
    read_all("R4 wake");
    long_idle();
    clear_flags();
    wake_en_i = 1'b0; par_en_i = 1'b0;
    long_idle();

    // R7 overrun: fifth byte dropped
    send_frame(8'h01, 0, 0, 0, -1);
    send_frame(8'h02, 0, 0, 0, -1);
    send_frame(8'h03, 0, 0, 0, -1);
    send_frame(8'h04, 0, 0, 0, -1);
    send_frame(8'h05, 0, 0, 0, -1);
    chk("R7", "ovr", err_ovr_o, 1'b1);
    compare_all("R7");
    read_all("R7");
    send_frame(8'h06, 0, 0, 0, -1);
    compare_all("R10 after ovr");
    read_all("R10");
    long_idle();
    clear_flags();
    compare_all("R10 final");

    finished = 1;
    summary();
    $finish;
  end
endmodule